// File: doc/BRIEF.md
# IOMMU Debug Translation Request Port

This block gives software a way to ask the address translation unit to translate a single I/O virtual address and read back the result. It has three 64-bit registers on a simple register write/read bus: a request address register, a request control register and a response register. Software writes the virtual address, then writes the control register with the go/busy bit set. The go/busy bit starts one translation on a request/response handshake toward an external translation engine.

The engine looks up the device context for the device ID and process ID, walks the tables, and returns one of three results. It can report that no valid context exists, report a fault with a cause code, or return a physical address. The block packs that result into the response word and clears go/busy in the same cycle. Software polls go/busy and reads the response once the bit reads zero. A capability register reports the debug feature, and that bit is always set.

Top module: `iommu_dbg_xlate`

## Requirements
- R1: After reset the address, control and response registers read as zero and `xl_req_o` is low.
- R2: The capability register is at offset 0x000 and always reads with bit 31 set. The address register is at 0x258, control at 0x260 and response at 0x268. Unmapped offsets read zero.
- R3: In the control word, bit 0 is go/busy, bit 3 is no-write, bits 31:12 are the process ID and bits 63:40 are the device ID. All other bits read zero. An accepted write with bit 0 set raises `xl_req_o` in the next cycle. The request carries the stored address, device ID and process ID.
- R4: `xl_rdonly_o` equals the stored no-write bit: 1 asks for read-only permission and 0 asks for read/write permission.
- R5: A control write with bit 0 clear launches nothing and leaves all three registers unchanged.
- R6: If the engine reports a missing context, the response is bit 0 set with cause 256 (DMA disabled) starting at bit 10, and every other bit zero.
- R7: If the engine reports a fault, the response is bit 0 set with the engine's 12-bit cause code at bits 21:10, and every other bit zero.
- R8: On success, the response is the physical address shifted right by 12 and masked to bits 53:10. Bit 0 and bit 9 (superpage) are zero.
- R9: `xl_req_o` is sampled high with `xl_rsp_valid_i` high at a clock edge. At that edge the response register is written, go/busy clears and `xl_req_o` falls. The same sequence applies to faults and successes.
- R10: While go/busy is set, writes to the address and control registers are ignored.
- R11: Writes to the response and capability registers are ignored.
- R12: While `xl_req_o` stays high, the address, device ID, process ID and no-write outputs stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data for `reg_addr_i`, combinational |
| xl_req_o | output | 1 | Translation request pending |
| xl_iova_o | output | 64 | Virtual address to translate |
| xl_did_o | output | 24 | Device ID |
| xl_pid_o | output | 20 | Process ID |
| xl_rdonly_o | output | 1 | 1 requests read-only permission |
| xl_rsp_valid_i | input | 1 | Engine result valid; accepted while `xl_req_o` is high |
| xl_ctx_miss_i | input | 1 | No valid device context |
| xl_fault_i | input | 1 | Translation fault |
| xl_cause_i | input | 12 | Fault cause code |
| xl_pa_i | input | 64 | Translated physical address |

## Verification
The assertions assume the engine raises `xl_rsp_valid_i` only while `xl_req_o` is high. They also assume the engine holds the result qualifiers valid for that cycle. Under those assumptions the response-format checks, and the check that busy tracks the request, hold only for handshakes the block actually accepts. The bench models the engine with a single task. That task waits a chosen number of cycles after the request rises, drives a one-cycle response on the falling edge, and drops it again. The bench never pulses a response while idle and never overlaps two requests.

// File: rtl/iommu_dbg_pkg.sv
package iommu_dbg_pkg;
  localparam int REG_W     = 64;
  localparam int ADDR_W    = 12;
  localparam int PID_W     = 20;
  localparam int DID_W     = 24;
  localparam int CAUSE_W   = 12;

  localparam logic [ADDR_W-1:0] OFF_CAP  = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_IOVA = 12'h258;
  localparam logic [ADDR_W-1:0] OFF_CTL  = 12'h260;
  localparam logic [ADDR_W-1:0] OFF_RSP  = 12'h268;

  localparam int CAP_DBG_BIT = 31;
  localparam int CTL_GO      = 0;
  localparam int CTL_NW      = 3;
  localparam int CTL_PID_LO  = 12;
  localparam int CTL_DID_LO  = 40;

  localparam int RSP_FAULT   = 0;
  localparam int RSP_SP      = 9;
  localparam int RSP_CAUSE_LO = 10;
  localparam int RSP_PPN_LO  = 10;
  localparam int RSP_PPN_HI  = 53;
  localparam int PAGE_SHIFT  = 12;

  localparam logic [CAUSE_W-1:0] CAUSE_DMA_OFF = 12'd256;

  typedef struct packed {
    logic [DID_W-1:0] did;
    logic [PID_W-1:0] pid;
    logic             nw;
    logic             go;
  } ctl_t;

  function automatic logic [REG_W-1:0] ctl_pack(ctl_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[CTL_GO] = c.go;
    w[CTL_NW] = c.nw;
    w[CTL_PID_LO +: PID_W] = c.pid;
    w[CTL_DID_LO +: DID_W] = c.did;
    return w;
  endfunction

  function automatic ctl_t ctl_unpack(logic [REG_W-1:0] w);
    ctl_t c;
    c.go  = w[CTL_GO];
    c.nw  = w[CTL_NW];
    c.pid = w[CTL_PID_LO +: PID_W];
    c.did = w[CTL_DID_LO +: DID_W];
    return c;
  endfunction
endpackage

// File: rtl/iommu_dbg_rsp.sv
module iommu_dbg_rsp
  import iommu_dbg_pkg::*;
(
  input  logic               ctx_miss_i,
  input  logic               fault_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [REG_W-1:0]   pa_i,
  output logic [REG_W-1:0]   word_o
);
  localparam logic [REG_W-1:0] PPN_MASK =
    ((REG_W'(1) << (RSP_PPN_HI + 1)) - REG_W'(1)) & ~((REG_W'(1) << RSP_PPN_LO) - REG_W'(1));

  logic [REG_W-1:0] flt_word;
  logic [REG_W-1:0] ok_word;
  logic [CAUSE_W-1:0] sel_cause;

  always_comb begin
    sel_cause = ctx_miss_i ? CAUSE_DMA_OFF : cause_i;
    flt_word  = '0;
    flt_word[RSP_FAULT] = 1'b1;
    flt_word[RSP_CAUSE_LO +: CAUSE_W] = sel_cause;
    ok_word   = (pa_i >> PAGE_SHIFT) & PPN_MASK;
    ok_word[RSP_SP]    = 1'b0;  // no superpages
    ok_word[RSP_FAULT] = 1'b0;
    word_o = (ctx_miss_i || fault_i) ? flt_word : ok_word;
  end
endmodule

// File: rtl/iommu_dbg_seq.sv
module iommu_dbg_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  input  logic rsp_valid_i,
  output logic req_o,
  output logic done_o
);
  typedef enum logic {S_IDLE, S_WAIT} state_e;
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    done_o  = 1'b0;
    unique case (state_q)
      S_IDLE: if (launch_i) state_d = S_WAIT;
      S_WAIT: if (rsp_valid_i) begin
        done_o  = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;

  assign req_o = (state_q == S_WAIT);
endmodule

// File: rtl/iommu_dbg_regs.sv
module iommu_dbg_regs
  import iommu_dbg_pkg::*;
#(
  parameter logic [REG_W-1:0] CAP_BASE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              done_i,
  input  logic [REG_W-1:0]  rsp_word_i,
  output logic              launch_o,
  output logic              busy_o,
  output logic [REG_W-1:0]  iova_o,
  output ctl_t              ctl_o,
  output logic [REG_W-1:0]  rsp_o
);
  localparam logic [REG_W-1:0] CAP_VAL = CAP_BASE | (REG_W'(1) << CAP_DBG_BIT);

  logic [REG_W-1:0] iova_q, rsp_q;
  ctl_t             ctl_q, wr_ctl;
  logic             iova_we;

  assign busy_o   = ctl_q.go;
  assign wr_ctl   = ctl_unpack(wdata_i);
  assign iova_we  = we_i && (addr_i == OFF_IOVA) && !ctl_q.go;
  assign launch_o = we_i && (addr_i == OFF_CTL) && wr_ctl.go && !ctl_q.go;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iova_q <= '0;
      ctl_q  <= '0;
      rsp_q  <= '0;
    end else begin
      if (iova_we)  iova_q <= wdata_i;
      if (launch_o) ctl_q  <= wr_ctl;
      else if (done_i) ctl_q.go <= 1'b0;
      if (done_i)   rsp_q  <= rsp_word_i;
    end
  end

  always_comb begin
    unique case (addr_i)
      OFF_CAP:  rdata_o = CAP_VAL;
      OFF_IOVA: rdata_o = iova_q;
      OFF_CTL:  rdata_o = ctl_pack(ctl_q);
      OFF_RSP:  rdata_o = rsp_q;
      default:  rdata_o = '0;
    endcase
  end

  assign iova_o = iova_q;
  assign ctl_o  = ctl_q;
  assign rsp_o  = rsp_q;
endmodule

// File: rtl/iommu_dbg_xlate.sv
module iommu_dbg_xlate
  import iommu_dbg_pkg::*;
#(
  parameter logic [REG_W-1:0] CAP_BASE = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  output logic               xl_req_o,
  output logic [REG_W-1:0]   xl_iova_o,
  output logic [DID_W-1:0]   xl_did_o,
  output logic [PID_W-1:0]   xl_pid_o,
  output logic               xl_rdonly_o,
  input  logic               xl_rsp_valid_i,
  input  logic               xl_ctx_miss_i,
  input  logic               xl_fault_i,
  input  logic [CAUSE_W-1:0] xl_cause_i,
  input  logic [REG_W-1:0]   xl_pa_i
);
  logic             launch, busy, done;
  logic [REG_W-1:0] rsp_word, rsp_q;
  ctl_t             ctl_q;

  iommu_dbg_regs #(.CAP_BASE(CAP_BASE)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .done_i(done), .rsp_word_i(rsp_word),
    .launch_o(launch), .busy_o(busy), .iova_o(xl_iova_o), .ctl_o(ctl_q), .rsp_o(rsp_q)
  );

  iommu_dbg_seq u_seq (
    .clk_i, .rst_ni, .launch_i(launch), .rsp_valid_i(xl_rsp_valid_i),
    .req_o(xl_req_o), .done_o(done)
  );

  iommu_dbg_rsp u_rsp (
    .ctx_miss_i(xl_ctx_miss_i), .fault_i(xl_fault_i), .cause_i(xl_cause_i),
    .pa_i(xl_pa_i), .word_o(rsp_word)
  );

  assign xl_did_o    = ctl_q.did;
  assign xl_pid_o    = ctl_q.pid;
  assign xl_rdonly_o = ctl_q.nw;
endmodule

// File: rtl/iommu_dbg_chk.sv
module iommu_dbg_chk
  import iommu_dbg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [REG_W-1:0]  wdata_i,
  input logic              req_i,
  input logic              busy_i,
  input logic              rsp_valid_i,
  input logic              ctx_miss_i,
  input logic              fault_i,
  input logic [REG_W-1:0]  iova_i,
  input logic [DID_W-1:0]  did_i,
  input logic [PID_W-1:0]  pid_i,
  input logic              rdonly_i,
  input logic [REG_W-1:0]  rsp_q_i
);
  // R9
  busy_tracks_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i == req_i);
  // R9
  done_clears_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && rsp_valid_i |=> !req_i);
  // R12
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !rsp_valid_i |=> $stable(iova_i) && $stable(did_i) && $stable(pid_i) && $stable(rdonly_i));
  // R8
  ok_rsp_fmt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && rsp_valid_i && !ctx_miss_i && !fault_i |=> !rsp_q_i[RSP_FAULT] && !rsp_q_i[RSP_SP]);
  // R7
  fault_rsp_fmt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && rsp_valid_i && (fault_i || ctx_miss_i) |=> rsp_q_i[RSP_FAULT]);
  // R10
  iova_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && addr_i == OFF_IOVA |=> $stable(iova_i));
  // R5
  no_go_no_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i && we_i && addr_i == OFF_CTL && !wdata_i[CTL_GO] |=> !req_i);
  // R11
  rsp_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == OFF_RSP && !(req_i && rsp_valid_i) |=> $stable(rsp_q_i));
endmodule

bind iommu_dbg_xlate iommu_dbg_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
  .req_i(xl_req_o), .busy_i(busy), .rsp_valid_i(xl_rsp_valid_i), .ctx_miss_i(xl_ctx_miss_i),
  .fault_i(xl_fault_i), .iova_i(xl_iova_o), .did_i(xl_did_o), .pid_i(xl_pid_o),
  .rdonly_i(xl_rdonly_o), .rsp_q_i(rsp_q)
);

// File: tb/iommu_dbg_xlate_bench.sv
module iommu_dbg_xlate_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_CAP = 12'h000, A_IOVA = 12'h258, A_CTL = 12'h260, A_RSP = 12'h268;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0, rdata;
  logic        req, rdonly;
  logic [63:0] xiova, pa = '0;
  logic [23:0] did;
  logic [19:0] pid;
  logic        rsp_valid = 1'b0, miss = 1'b0, fault = 1'b0;
  logic [11:0] cause = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iommu_dbg_xlate u_iommu_dbg_xlate (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .xl_req_o(req), .xl_iova_o(xiova), .xl_did_o(did), .xl_pid_o(pid),
    .xl_rdonly_o(rdonly), .xl_rsp_valid_i(rsp_valid), .xl_ctx_miss_i(miss), .xl_fault_i(fault),
    .xl_cause_i(cause), .xl_pa_i(pa)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [63:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [11:0] a, output logic [63:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  function automatic logic [63:0] mk_ctl(logic [23:0] dv, logic [19:0] pv, logic nw, logic go);
    return {dv, 8'h0, pv, 8'h0, nw, 2'b0, go};
  endfunction

  function automatic logic [63:0] exp_ok(logic [63:0] p);
    return ((p >> 12) & ~64'h3FF) & ((64'd1 << 54) - 64'd1);
  endfunction

  // after a go write: engine answers after lat cycles; returns response and ctl readback
  task automatic finish_req(int lat, logic m, logic f, logic [11:0] c, logic [63:0] p,
                            output logic [63:0] rsp_rd, output logic [63:0] ctl_rd);
    repeat (lat) @(negedge clk);
    rsp_valid = 1'b1; miss = m; fault = f; cause = c; pa = p;
    @(negedge clk);
    rsp_valid = 1'b0; miss = 1'b0; fault = 1'b0; cause = '0; pa = '0;
    check("R9 req low after response", {63'd0, req}, 64'd0);
    rd(A_RSP, rsp_rd);
    rd(A_CTL, ctl_rd);
  endtask

  task automatic t_reset();
    logic [63:0] v;
    check("R1 req idle", {63'd0, req}, 64'd0);
    rd(A_IOVA, v); check("R1 iova zero", v, 64'd0);
    rd(A_CTL, v);  check("R1 ctl zero", v, 64'd0);
    rd(A_RSP, v);  check("R1 rsp zero", v, 64'd0);
  endtask

  task automatic t_cap();
    logic [63:0] v;
    rd(A_CAP, v); check("R2 cap bit31", {63'd0, v[31]}, 64'd1);
    wr(A_CAP, 64'h0);
    rd(A_CAP, v); check("R11 cap unwritable", {63'd0, v[31]}, 64'd1);
    rd(12'h100, v); check("R2 unmapped zero", v, 64'd0);
  endtask

  task automatic t_nogo();
    logic [63:0] v;
    wr(A_IOVA, 64'hDEAD_0000_1000);
    wr(A_CTL, mk_ctl(24'hABCDEF, 20'h12345, 1'b1, 1'b0));
    check("R5 no launch", {63'd0, req}, 64'd0);
    rd(A_CTL, v);  check("R5 ctl unchanged", v, 64'd0);
    rd(A_RSP, v);  check("R5 rsp unchanged", v, 64'd0);
    rd(A_IOVA, v); check("R5 iova unchanged", v, 64'hDEAD_0000_1000);
  endtask

  task automatic t_ok();
    logic [63:0] r, c;
    logic [63:0] p;
    p = 64'h0000_1234_5678_9ABC;
    wr(A_IOVA, 64'h0000_7FFF_0000_3000);
    wr(A_CTL, mk_ctl(24'h00_0042, 20'h0_0007, 1'b0, 1'b1) | 64'h0000_00F0_0000_0FF4);
    check("R3 req raised", {63'd0, req}, 64'd1);
    check("R3 iova out", xiova, 64'h0000_7FFF_0000_3000);
    check("R3 did out", {40'd0, did}, 64'h42);
    check("R3 pid out", {44'd0, pid}, 64'h7);
    check("R4 read-write", {63'd0, rdonly}, 64'd0);
    rd(A_CTL, c); check("R3 ctl readback busy", c, mk_ctl(24'h42, 20'h7, 1'b0, 1'b1));
    finish_req(3, 1'b0, 1'b0, 12'h0, p, r, c);
    check("R8 success ppn", r, exp_ok(p));
    check("R9 go cleared", {63'd0, c[0]}, 64'd0);
    check("R3 ctl fields kept", c, mk_ctl(24'h42, 20'h7, 1'b0, 1'b0));
    wr(A_CTL, mk_ctl(24'h1, 20'h1, 1'b0, 1'b1));
    finish_req(0, 1'b0, 1'b0, 12'h0, 64'hFFFF_FFFF_FFFF_FFFF, r, c);
    check("R8 superpage/fault bits zero", r, exp_ok(64'hFFFF_FFFF_FFFF_FFFF));
  endtask

  task automatic t_fault();
    logic [63:0] r, c;
    wr(A_CTL, mk_ctl(24'hFFFFFF, 20'hFFFFF, 1'b1, 1'b1));
    check("R4 read-only", {63'd0, rdonly}, 64'd1);
    check("R3 did max", {40'd0, did}, 64'hFF_FFFF);
    finish_req(2, 1'b0, 1'b1, 12'hFA5, 64'h1234_5000, r, c);
    check("R7 fault word", r, 64'd1 | (64'hFA5 << 10));
    check("R9 go cleared on fault", {63'd0, c[0]}, 64'd0);
  endtask

  task automatic t_miss();
    logic [63:0] r, c;
    wr(A_CTL, mk_ctl(24'h9, 20'h3, 1'b0, 1'b1));
    finish_req(1, 1'b1, 1'b0, 12'h00F, 64'h9999_9000, r, c);
    check("R6 missing context word", r, 64'd1 | (64'd256 << 10));
    check("R9 go cleared on miss", {63'd0, c[0]}, 64'd0);
  endtask

  task automatic t_lock();
    logic [63:0] r, c, v;
    wr(A_IOVA, 64'h0000_0000_AAAA_0000);
    wr(A_CTL, mk_ctl(24'h55, 20'h66, 1'b0, 1'b1));
    wr(A_IOVA, 64'h0000_0000_BBBB_0000);
    wr(A_CTL, mk_ctl(24'h77, 20'h88, 1'b1, 1'b1));
    check("R10 iova out held", xiova, 64'h0000_0000_AAAA_0000);
    check("R12 did held", {40'd0, did}, 64'h55);
    check("R12 rdonly held", {63'd0, rdonly}, 64'd0);
    wr(A_RSP, 64'hFFFF);
    rd(A_RSP, v); check("R11 rsp write ignored", v, 64'd1 | (64'd256 << 10));
    finish_req(1, 1'b0, 1'b0, 12'h0, 64'h0000_0000_0004_2000, r, c);
    check("R8 ppn small", r, exp_ok(64'h0000_0000_0004_2000));
    rd(A_IOVA, v); check("R10 iova reg kept", v, 64'h0000_0000_AAAA_0000);
    check("R10 ctl write ignored", c, mk_ctl(24'h55, 20'h66, 1'b0, 1'b0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cap();
    t_nogo();
    t_ok();
    t_fault();
    t_miss();
    t_lock();
    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule